// File: doc/BRIEF.md
# Host Mailbox Parallel Port

This block is the slave side of a byte-wide parallel port. An external host processor uses it to pass data to and from an internal core through a small bank of mailbox registers. The host side has an 8-bit data bus, an active-low chip select, two strobe pins, an address-latch strobe, dedicated address lines and an acknowledge output. The core side is a plain synchronous register port with per-mailbox flags. The flags tell the core which mailboxes the host has filled and the core has not yet read. They also show which mailboxes the core has filled and the host has not yet read.

Two static mode pins set the host bus style. The first chooses where the register address comes from. It comes either from three dedicated lines or from the low bits of the shared data bus, captured when the address-latch strobe falls. The second chooses between a read strobe plus a write strobe, and a direction line qualified by a single data strobe. All host pins are asynchronous to the core clock and pass through a synchronizer before use. The host waits for the acknowledge before it ends a strobe.

The address map holds six data mailboxes at addresses 0 to 5, a status word at address 6 and a shared control byte at address 7.

Top module: `host_mbox_port`

## Requirements
- R1: After reset every mailbox and the control byte read 0, all mailbox flags are 0, and `h_ack` and `h_data_oe` are 0.
- R2: With `mode_mux`=0 the register address is taken from `h_addr`. A host write of a byte to mailbox n is read back unchanged by the core at address n.
- R3: With `mode_mux`=1 the address is the low 3 bits of `h_din`, captured when `h_ale` falls. Later reads and writes use that captured address, whatever byte the bus carries during the strobe.
- R4: With `mode_split`=1, `h_rd_n` low is a read and `h_wr_n` low is a write. With `mode_split`=0, `h_wr_n` is an active-low data strobe and `h_rd_n` gives the direction, 1 for read and 0 for write. Both styles reach the same registers.
- R5: While `h_cs_n` is high, strobe activity neither writes a register nor raises `h_ack`.
- R6: `h_ack` rises on the 4th rising clock edge after a strobe becomes active with chip select low. It falls on the 3rd rising edge after the strobe ends.
- R7: `h_data_oe` is 1 exactly while chip select is low and a read strobe is active. It is 0 for writes and when idle.
- R8: A host write to mailbox n sets bit n of `c_hflags`. A core read of mailbox n clears it.
- R9: A core write to mailbox n sets bit n of `c_cflags`. A host read of mailbox n clears it. A host read of address 6 returns `c_cflags` in bits 5:0 with bits 7:6 zero. A core read of address 6 returns `c_hflags` in the same layout.
- R10: Address 7 is a control byte that both sides can write and read. A host write to address 6 changes nothing.
- R11: `c_rdata` holds the addressed value from the rising edge on which `c_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mux | input | 1 | 0: dedicated address lines, 1: address on data bus |
| mode_split | input | 1 | 1: read and write strobes, 0: direction plus data strobe |
| h_cs_n | input | 1 | Host chip select, active low |
| h_rd_n | input | 1 | Read strobe, or direction line (1 = read) |
| h_wr_n | input | 1 | Write strobe, or data strobe |
| h_ale | input | 1 | Address-latch strobe for the shared bus |
| h_addr | input | 3 | Dedicated register address |
| h_din | input | 8 | Host bus value into the port |
| h_data_out | output | 8 | Read data toward the host |
| h_data_oe | output | 1 | Drive enable for the host bus |
| h_ack | output | 1 | Access acknowledge |
| c_rd | input | 1 | Core read request |
| c_wr | input | 1 | Core write request |
| c_addr | input | 3 | Core register address |
| c_wdata | input | 8 | Core write data |
| c_rdata | output | 8 | Core read data, registered |
| c_hflags | output | 6 | Mailboxes written by the host and unread by the core |
| c_cflags | output | 6 | Mailboxes written by the core and unread by the host |

## Verification
A host pin change reaches the decode logic after two synchronizer edges. Read data and flag clearing follow on the third edge, a host write lands on the third edge after the strobe ends, and `h_ack` rises on the fourth edge. The bench drives every host pin on falling edges and counts falling edges until `h_ack` rises, expecting exactly four. After release it samples `h_ack` at the second falling edge, expecting 1, and at the third, expecting 0. Flags and core-visible values are checked only after that window. Core reads are checked on the falling edge after the rising edge that samples `c_rd`.

// File: rtl/hmbox_pkg.sv
package hmbox_pkg;

   typedef enum logic {ADDR_DEDICATED = 1'b0, ADDR_SHARED = 1'b1} addr_style_e;
   typedef enum logic {STROBE_DIR = 1'b0, STROBE_SPLIT = 1'b1} strobe_style_e;

   // a_n: read strobe or direction line, b_n: write strobe or data strobe
   function automatic logic host_rd_act(input logic cs_n, input logic a_n,
                                        input logic b_n, input logic split);
      return !cs_n && (split ? !a_n : (a_n && !b_n));
   endfunction

   function automatic logic host_wr_act(input logic cs_n, input logic a_n,
                                        input logic b_n, input logic split);
      return !cs_n && (split ? !b_n : (!a_n && !b_n));
   endfunction

endpackage

// File: rtl/hmbox_sync.sv
module hmbox_sync #(
   parameter int          W      = 1,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("hmbox_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hmbox_host_fe.sv
module hmbox_host_fe
   import hmbox_pkg::*;
#(
   parameter int DW     = 8,
   parameter int AW     = 3,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_mux,
   input  logic          mode_split,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          ale,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          rd_ev,
   output logic          wr_ev,
   output logic [AW-1:0] acc_addr,
   output logic [DW-1:0] wr_data,
   output logic          ack,
   output logic          oe
);

   localparam int BW = 4 + AW + DW;
   localparam logic [BW-1:0] IDLE_VAL = {4'b1110, {AW{1'b0}}, {DW{1'b0}}};

   logic [BW-1:0] raw_bus, syn_bus;
   logic          cs_s_n, rd_s_n, wr_s_n, ale_s;
   logic [AW-1:0] addr_s, addr_q, lat_addr;
   logic [DW-1:0] din_s, data_q;
   logic          rd_s, wr_s, rd_q, wr_q, ale_q;

   assign raw_bus = {cs_n, rd_n, wr_n, ale, addr, din};

   hmbox_sync #(.W(BW), .STAGES(STAGES), .RST(IDLE_VAL)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_bus),
      .q    (syn_bus)
   );

   assign {cs_s_n, rd_s_n, wr_s_n, ale_s, addr_s, din_s} = syn_bus;

   assign rd_s = host_rd_act(cs_s_n, rd_s_n, wr_s_n, mode_split);
   assign wr_s = host_wr_act(cs_s_n, rd_s_n, wr_s_n, mode_split);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= 1'b0;
         wr_q     <= 1'b0;
         ale_q    <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
         lat_addr <= '0;
         ack      <= 1'b0;
      end else begin
         rd_q   <= rd_s;
         wr_q   <= wr_s;
         ale_q  <= ale_s;
         addr_q <= addr_s;
         data_q <= din_s;
         if (ale_q && !ale_s) lat_addr <= data_q[AW-1:0];
         ack    <= (rd_s && rd_q) || (wr_s && wr_q);
      end
   end

   assign rd_ev    = rd_s && !rd_q;
   assign wr_ev    = wr_q && !wr_s;
   assign wr_data  = data_q;
   assign acc_addr = (mode_mux == ADDR_SHARED) ? lat_addr
                   : (wr_ev ? addr_q : addr_s);
   assign oe       = host_rd_act(cs_n, rd_n, wr_n, mode_split);

endmodule

// File: rtl/hmbox_regs.sv
module hmbox_regs #(
   parameter int DW   = 8,
   parameter int AW   = 3,
   parameter int NBOX = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            h_rd,
   input  logic            h_wr,
   input  logic [AW-1:0]   h_addr,
   input  logic [DW-1:0]   h_wdata,
   output logic [DW-1:0]   h_rdata,
   input  logic            c_rd,
   input  logic            c_wr,
   input  logic [AW-1:0]   c_addr,
   input  logic [DW-1:0]   c_wdata,
   output logic [DW-1:0]   c_rdata,
   output logic [NBOX-1:0] hflags,
   output logic [NBOX-1:0] cflags
);

   localparam logic [AW-1:0] STAT_A = AW'(NBOX);
   localparam logic [AW-1:0] CTRL_A = AW'(NBOX + 1);

   logic [NBOX-1:0][DW-1:0] box;
   logic [DW-1:0]           ctrl;

   for (genvar i = 0; i < NBOX; i++) begin : g_box
      logic          hw_hit, hr_hit, cw_hit, cr_hit;
      logic [DW-1:0] val;
      logic          hf, cf;

      assign hw_hit = h_wr && (h_addr == AW'(i));
      assign hr_hit = h_rd && (h_addr == AW'(i));
      assign cw_hit = c_wr && (c_addr == AW'(i));
      assign cr_hit = c_rd && (c_addr == AW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val <= '0;
            hf  <= 1'b0;
            cf  <= 1'b0;
         end else begin
            if (hw_hit)      val <= h_wdata;
            else if (cw_hit) val <= c_wdata;
            if (hw_hit)      hf <= 1'b1;
            else if (cr_hit) hf <= 1'b0;
            if (cw_hit && !hw_hit) cf <= 1'b1;
            else if (hr_hit)       cf <= 1'b0;
         end
      end

      assign box[i]    = val;
      assign hflags[i] = hf;
      assign cflags[i] = cf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ctrl <= '0;
      else if (h_wr && h_addr == CTRL_A)    ctrl <= h_wdata;
      else if (c_wr && c_addr == CTRL_A)    ctrl <= c_wdata;
   end

   function automatic logic [DW-1:0] pick(input logic [AW-1:0] a,
                                          input logic [NBOX-1:0] peer);
      logic [DW-1:0] r;
      r = '0;
      for (int i = 0; i < NBOX; i++)
         if (a == AW'(i)) r = box[i];
      if (a == STAT_A) r = DW'(peer);
      if (a == CTRL_A) r = ctrl;
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_rdata <= '0;
         c_rdata <= '0;
      end else begin
         if (h_rd) h_rdata <= pick(h_addr, cflags);
         if (c_rd) c_rdata <= pick(c_addr, hflags);
      end
   end

endmodule

// File: rtl/host_mbox_port.sv
module host_mbox_port #(
   parameter int DW     = 8,
   parameter int AW     = 3,
   parameter int NBOX   = 6,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_mux,
   input  logic            mode_split,
   input  logic            h_cs_n,
   input  logic            h_rd_n,
   input  logic            h_wr_n,
   input  logic            h_ale,
   input  logic [AW-1:0]   h_addr,
   input  logic [DW-1:0]   h_din,
   output logic [DW-1:0]   h_data_out,
   output logic            h_data_oe,
   output logic            h_ack,
   input  logic            c_rd,
   input  logic            c_wr,
   input  logic [AW-1:0]   c_addr,
   input  logic [DW-1:0]   c_wdata,
   output logic [DW-1:0]   c_rdata,
   output logic [NBOX-1:0] c_hflags,
   output logic [NBOX-1:0] c_cflags
);

   generate
      if (NBOX + 2 > (1 << AW)) begin : g_bad_map
         $error("address space too small for mailboxes, status and control");
      end
      if (NBOX > DW || AW > DW) begin : g_bad_width
         $error("flags and address must fit in one data word");
      end
   endgenerate

   logic          h_rd_ev, h_wr_ev;
   logic [AW-1:0] h_acc_addr;
   logic [DW-1:0] h_wr_data;

   hmbox_host_fe #(.DW(DW), .AW(AW), .STAGES(STAGES)) u_fe (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_mux  (mode_mux),
      .mode_split(mode_split),
      .cs_n      (h_cs_n),
      .rd_n      (h_rd_n),
      .wr_n      (h_wr_n),
      .ale       (h_ale),
      .addr      (h_addr),
      .din       (h_din),
      .rd_ev     (h_rd_ev),
      .wr_ev     (h_wr_ev),
      .acc_addr  (h_acc_addr),
      .wr_data   (h_wr_data),
      .ack       (h_ack),
      .oe        (h_data_oe)
   );

   hmbox_regs #(.DW(DW), .AW(AW), .NBOX(NBOX)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .h_rd   (h_rd_ev),
      .h_wr   (h_wr_ev),
      .h_addr (h_acc_addr),
      .h_wdata(h_wr_data),
      .h_rdata(h_data_out),
      .c_rd   (c_rd),
      .c_wr   (c_wr),
      .c_addr (c_addr),
      .c_wdata(c_wdata),
      .c_rdata(c_rdata),
      .hflags (c_hflags),
      .cflags (c_cflags)
   );

endmodule

// File: rtl/hmbox_chk.sv
module hmbox_chk #(
   parameter int AW   = 3,
   parameter int NBOX = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            h_cs_n,
   input logic            h_data_oe,
   input logic            h_ack,
   input logic            c_rd,
   input logic            c_wr,
   input logic [AW-1:0]   c_addr,
   input logic [NBOX-1:0] c_hflags,
   input logic [NBOX-1:0] c_cflags,
   input logic            host_wr_ev
);

   // R1
   reset_clean_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!h_ack && c_hflags == '0 && c_cflags == '0));

   // R7
   oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_data_oe |-> !h_cs_n);

   // R6
   ack_after_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(h_ack) |-> $past(!h_cs_n, 3));

   // R8
   core_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd && c_addr < AW'(NBOX) && !host_wr_ev) |=> !c_hflags[$past(c_addr)]);

   // R9
   core_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr && c_addr < AW'(NBOX) && !host_wr_ev) |=> c_cflags[$past(c_addr)]);

endmodule

bind host_mbox_port hmbox_chk #(.AW(AW), .NBOX(NBOX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .h_cs_n    (h_cs_n),
   .h_data_oe (h_data_oe),
   .h_ack     (h_ack),
   .c_rd      (c_rd),
   .c_wr      (c_wr),
   .c_addr    (c_addr),
   .c_hflags  (c_hflags),
   .c_cflags  (c_cflags),
   .host_wr_ev(h_wr_ev)
);

// File: tb/host_mbox_port_tb.sv
module host_mbox_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_mux = 1'b0, mode_split = 1'b1;
   logic       h_cs_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1, h_ale = 1'b0;
   logic [2:0] h_addr = '0;
   logic [7:0] h_din = '0;
   logic [7:0] h_data_out;
   logic       h_data_oe, h_ack;
   logic       c_rd = 1'b0, c_wr = 1'b0;
   logic [2:0] c_addr = '0;
   logic [7:0] c_wdata = '0, c_rdata;
   logic [5:0] c_hflags, c_cflags;

   int total = 0, bad = 0;
   int ack_rise_n;
   logic oe_seen, ack_at2, ack_at3, oe_after;

   always #2 clk = ~clk;

   host_mbox_port u_dut (
      .clk(clk), .rst_n(rst_n), .mode_mux(mode_mux), .mode_split(mode_split),
      .h_cs_n(h_cs_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_ale(h_ale),
      .h_addr(h_addr), .h_din(h_din), .h_data_out(h_data_out),
      .h_data_oe(h_data_oe), .h_ack(h_ack), .c_rd(c_rd), .c_wr(c_wr),
      .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
      .c_hflags(c_hflags), .c_cflags(c_cflags)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_acc(input bit is_rd, input logic [2:0] a,
                           input logic [7:0] d, output logic [7:0] q);
      int n;
      if (mode_mux) begin
         h_din = {5'b0, a};
         h_ale = 1'b1;
         repeat (3) @(negedge clk);
         h_ale = 1'b0;
         repeat (3) @(negedge clk);
      end else begin
         h_addr = a;
      end
      h_din  = d;
      h_cs_n = 1'b0;
      if (!mode_split) h_rd_n = is_rd;
      @(negedge clk);
      if (mode_split) begin
         if (is_rd) h_rd_n = 1'b0; else h_wr_n = 1'b0;
      end else begin
         h_wr_n = 1'b0;
      end
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!h_ack && n < 20);
      ack_rise_n = n;
      oe_seen = h_data_oe;
      q = h_data_out;
      h_wr_n = 1'b1;
      if (mode_split) h_rd_n = 1'b1;
      @(negedge clk);
      @(negedge clk); ack_at2 = h_ack;
      @(negedge clk); ack_at3 = h_ack;
      @(negedge clk); oe_after = h_data_oe;
      h_cs_n = 1'b1;
      h_rd_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic core_wr(input logic [2:0] a, input logic [7:0] d);
      c_wr = 1'b1; c_addr = a; c_wdata = d;
      @(negedge clk);
      c_wr = 1'b0;
   endtask

   task automatic core_rd(input logic [2:0] a, output logic [7:0] q);
      c_rd = 1'b1; c_addr = a;
      @(negedge clk);
      c_rd = 1'b0;
      q = c_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] q;
      chk("R1 ack", {7'b0, h_ack}, 8'h00);
      chk("R1 oe", {7'b0, h_data_oe}, 8'h00);
      chk("R1 hflags", {2'b0, c_hflags}, 8'h00);
      chk("R1 cflags", {2'b0, c_cflags}, 8'h00);
      core_rd(3'd0, q); chk("R1 box0", q, 8'h00);
      core_rd(3'd7, q); chk("R1 ctrl", q, 8'h00);
   endtask

   task automatic t_ack_timing();
      logic [7:0] q;
      mode_mux = 1'b0; mode_split = 1'b1;
      host_acc(1'b0, 3'd2, 8'hA5, q);
      chk("R6 rise edge count", 8'(ack_rise_n), 8'd4);
      chk("R6 still high 2 after release", {7'b0, ack_at2}, 8'h01);
      chk("R6 low 3 after release", {7'b0, ack_at3}, 8'h00);
      chk("R7 oe low on write", {7'b0, oe_seen}, 8'h00);
      chk("R8 hflag set", {2'b0, c_hflags}, 8'h04);
      core_rd(3'd6, q); chk("R9 core status", q, 8'h04);
      core_rd(3'd2, q); chk("R2 core sees host byte", q, 8'hA5);
      chk("R11 core read same value", c_rdata, 8'hA5);
      chk("R8 hflag cleared", {2'b0, c_hflags}, 8'h00);
   endtask

   task automatic t_core_to_host();
      logic [7:0] q;
      core_wr(3'd4, 8'h3C);
      chk("R9 cflag set", {2'b0, c_cflags}, 8'h10);
      host_acc(1'b1, 3'd6, 8'h00, q); chk("R9 host status", q, 8'h10);
      host_acc(1'b1, 3'd4, 8'h00, q);
      chk("R2 host reads box4", q, 8'h3C);
      chk("R7 oe during read", {7'b0, oe_seen}, 8'h01);
      chk("R7 oe after read", {7'b0, oe_after}, 8'h00);
      chk("R9 cflag cleared", {2'b0, c_cflags}, 8'h00);
      host_acc(1'b1, 3'd6, 8'h00, q); chk("R9 host status empty", q, 8'h00);
   endtask

   task automatic t_no_select();
      logic [7:0] q;
      h_addr = 3'd1; h_din = 8'hEE; h_cs_n = 1'b1;
      h_wr_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R5 no ack without select", {7'b0, h_ack}, 8'h00);
      h_wr_n = 1'b1; h_rd_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R7 no oe without select", {7'b0, h_data_oe}, 8'h00);
      chk("R5 no ack on read", {7'b0, h_ack}, 8'h00);
      h_rd_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R5 no flag", {2'b0, c_hflags}, 8'h00);
      core_rd(3'd1, q); chk("R5 box1 untouched", q, 8'h00);
   endtask

   task automatic t_shared_bus();
      logic [7:0] q;
      mode_mux = 1'b1; mode_split = 1'b1;
      host_acc(1'b0, 3'd5, 8'h71, q);
      chk("R3 hflag box5", {2'b0, c_hflags}, 8'h20);
      core_rd(3'd5, q); chk("R3 core reads box5", q, 8'h71);
      core_rd(3'd1, q); chk("R3 box1 not hit", q, 8'h00);
      host_acc(1'b1, 3'd5, 8'h02, q); chk("R3 host reads box5", q, 8'h71);
   endtask

   task automatic t_dir_strobe();
      logic [7:0] q;
      mode_mux = 1'b0; mode_split = 1'b0;
      host_acc(1'b0, 3'd0, 8'h5A, q);
      chk("R4 write oe low", {7'b0, oe_seen}, 8'h00);
      core_rd(3'd0, q); chk("R4 core reads box0", q, 8'h5A);
      host_acc(1'b1, 3'd0, 8'h00, q);
      chk("R4 host reads box0", q, 8'h5A);
      chk("R4 read oe high", {7'b0, oe_seen}, 8'h01);
      mode_mux = 1'b1;
      host_acc(1'b0, 3'd3, 8'h96, q);
      core_rd(3'd3, q); chk("R4 shared bus with direction", q, 8'h96);
   endtask

   task automatic t_control();
      logic [7:0] q;
      mode_mux = 1'b0; mode_split = 1'b1;
      host_acc(1'b0, 3'd7, 8'hC3, q);
      core_rd(3'd7, q); chk("R10 core reads ctrl", q, 8'hC3);
      core_wr(3'd7, 8'h3E);
      host_acc(1'b1, 3'd7, 8'h00, q); chk("R10 host reads ctrl", q, 8'h3E);
      host_acc(1'b0, 3'd6, 8'hFF, q);
      host_acc(1'b1, 3'd6, 8'h00, q); chk("R10 status not writable", q, 8'h00);
      chk("R10 no flag from status write", {2'b0, c_hflags}, 8'h00);
   endtask

   initial begin
      #(4 * 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_ack_timing();
      t_core_to_host();
      t_no_select();
      t_shared_bus();
      t_dir_strobe();
      t_control();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule